// File: doc/BRIEF.md
# Four-Channel Timer Compare Unit

This block sits next to a free-running time counter and watches it on up to four independent compare channels. Each channel holds an armed compare value. When the counter input equals that value on a clock edge, the channel latches a sticky match flag and drives its output pin according to its programmed action: invert the pin, or raise it for a single clock cycle. The flags can raise a shared interrupt line and per-channel DMA request lines.

The compare value has two stages. The first value written to a disarmed channel arms it at once. A second write is parked behind it, and the parked value takes over at the moment the armed one matches. Software can therefore always stay one event ahead. After each match it writes the value for the event after the next one, which gives periodic outputs with no gaps, such as a one-pulse-per-second line. Registers are reached through a simple write port and a read port with a registered result.

Top module: `tcmp_bank`

## Requirements
- R1: After synchronous reset, every pin, flag, `irq`, `dma_req` bit and `rd_data` is zero, and every channel has mode 0 and is disarmed.
- R2: Addresses: channel n control at 0x608+8n, channel n compare at 0x60C+8n, and the flag summary at 0x604, whose bit n is channel n's flag. `rd_data` shows the addressed register one cycle after `rd_en`.
- R3: Control register layout: bit 7 is the match flag, bit 6 the interrupt enable, bits 5:2 the mode and bit 0 the DMA enable. Bit 1 and bits above 7 read as zero.
- R4: A channel with a nonzero mode and an armed compare value sets its flag at the clock edge where `cnt_in` equals that value. A channel in mode 0 never sets its flag.
- R5: Writing a control word with bit 7 set clears the flag, and writing 0 there leaves it unchanged. A match in the same cycle takes priority, so the flag ends up set.
- R6: In mode 0101 the pin inverts at each match edge and otherwise holds its level.
- R7: In mode 1111 the pin is high for exactly the one cycle after a match edge and low otherwise.
- R8: A compare write to a disarmed channel arms it. A compare write to an armed channel fills the pending stage. At a match the pending value becomes the armed value, and if nothing is pending the channel disarms and does not match again. The compare address reads the armed value.
- R9: A compare write while both stages are full replaces the pending value.
- R10: Writing a control word whose mode is 0 empties both compare stages.
- R11: `irq` is the OR over channels of flag AND interrupt enable. `dma_req[n]` is channel n's flag AND DMA enable.
- R12: A control write that changes the mode drives the pin low. Any mode other than 0101 and 1111 sets the flag on a match and leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | CNT_W | Current time counter value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, valid one cycle after rd_en |
| ch_pin | output | NUM_CH | Per-channel compare output pins |
| dma_req | output | NUM_CH | Per-channel DMA request |
| irq | output | 1 | Combined compare interrupt |

## Verification
The bench builds the block with four channels and an 8-bit counter. The counter is a plain input driven by the bench, so it can jump straight onto or away from compare values. The random phase draws counter values and compare values from a 16-value range, so matches happen often. This brings within reach the orderings that matter: a match in the same cycle as a flag clear, a compare write in the same cycle as a promotion, an overwrite of the pending stage, and a mode change while the pin is high.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_OFF   = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_TOG   = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_PULSE = 4'b1111;

  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int MODE_LSB = 2;
  localparam int DMA_BIT  = 0;

  typedef struct packed {
    logic              flag;
    logic              ie;
    logic [MODE_W-1:0] mode;
    logic              dma;
  } csr_t;

  function automatic logic [7:0] csr_pack(input csr_t c);
    return {c.flag, c.ie, c.mode, 1'b0, c.dma};
  endfunction

  function automatic csr_t csr_unpack(input logic [7:0] w);
    csr_t c;
    c.flag = w[FLAG_BIT];
    c.ie   = w[IE_BIT];
    c.mode = w[MODE_LSB +: MODE_W];
    c.dma  = w[DMA_BIT];
    return c;
  endfunction
endpackage

// File: rtl/tcmp_regdec.sv
module tcmp_regdec #(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 12,
  parameter int CH_BASE   = 'h608,
  parameter int CH_STRIDE = 8,
  parameter int CMP_OFF   = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] csr_we,
  output logic [NUM_CH-1:0] cmp_we
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CH_BASE + g * CH_STRIDE);
    localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(CH_BASE + g * CH_STRIDE + CMP_OFF);
    assign csr_we[g] = wr_en && (wr_addr == CSR_A);
    assign cmp_we[g] = wr_en && (wr_addr == CMP_A);
  end
endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan
  import tcmp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             csr_we,
  input  csr_t             csr_wd,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wd,
  output csr_t             csr_o,
  output logic [CNT_W-1:0] act_o,
  output logic             pin_o
);
  csr_t             csr_q;
  logic [CNT_W-1:0] act_q, pend_q;
  logic             act_vld_q, pend_vld_q, pin_q;
  logic             hit, armed_after, mode_chg, disarm;

  assign hit         = (csr_q.mode != MODE_OFF) && act_vld_q && (cnt_i == act_q);
  assign armed_after = hit ? pend_vld_q : act_vld_q;
  assign mode_chg    = csr_we && (csr_wd.mode != csr_q.mode);
  assign disarm      = csr_we && (csr_wd.mode == MODE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q      <= '0;
      act_q      <= '0;
      pend_q     <= '0;
      act_vld_q  <= 1'b0;
      pend_vld_q <= 1'b0;
      pin_q      <= 1'b0;
    end else begin
      // sticky flag: a match outranks a clear
      if (hit)                        csr_q.flag <= 1'b1;
      else if (csr_we && csr_wd.flag) csr_q.flag <= 1'b0;
      if (csr_we) begin
        csr_q.ie   <= csr_wd.ie;
        csr_q.mode <= csr_wd.mode;
        csr_q.dma  <= csr_wd.dma;
      end
      // two-stage compare value
      if (disarm) begin
        act_vld_q  <= 1'b0;
        pend_vld_q <= 1'b0;
      end else begin
        if (hit) begin
          if (pend_vld_q) act_q <= pend_q;
          act_vld_q  <= pend_vld_q;
          pend_vld_q <= 1'b0;
        end
        if (cmp_we) begin
          if (armed_after) begin
            pend_q     <= cmp_wd;
            pend_vld_q <= 1'b1;
          end else begin
            act_q      <= cmp_wd;
            act_vld_q  <= 1'b1;
          end
        end
      end
      // output pin action
      if (mode_chg)                       pin_q <= 1'b0;
      else if (hit && csr_q.mode == MODE_TOG)   pin_q <= ~pin_q;
      else if (hit && csr_q.mode == MODE_PULSE) pin_q <= 1'b1;
      else if (csr_q.mode == MODE_PULSE)  pin_q <= 1'b0;
    end
  end

  assign csr_o = csr_q;
  assign act_o = act_q;
  assign pin_o = pin_q;

  // R4
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_q.flag) |-> $past(hit));
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && csr_we && csr_wd.flag && !hit) |-> !csr_q.flag);
  // R6
  tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(csr_q.mode) == MODE_TOG && $past(!csr_we) && pin_q != $past(pin_q))
      |-> $past(hit));
  // R7
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_q && csr_q.mode == MODE_PULSE) |-> $past(hit));
  // R8
  stage_order_chk: assert property (@(posedge clk) disable iff (rst)
    pend_vld_q |-> act_vld_q);
endmodule

// File: rtl/tcmp_bank.sv
module tcmp_bank
  import tcmp_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int SUM_ADDR  = 'h604,
  parameter int CH_BASE   = 'h608,
  parameter int CH_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] ch_pin,
  output logic [NUM_CH-1:0] dma_req,
  output logic              irq
);
  localparam int CMP_OFF = CH_STRIDE / 2;

  logic [NUM_CH-1:0] csr_we, cmp_we, flag_vec, irq_vec;
  csr_t              csr_arr [NUM_CH];
  logic [CNT_W-1:0]  act_arr [NUM_CH];
  csr_t              w_csr;
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_wr_bits;

  assign w_csr = csr_unpack(wr_data[7:0]);
  assign unused_wr_bits = ^{wr_data[1], wr_data[DATA_W-1:8]};

  tcmp_regdec #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE),
    .CH_STRIDE(CH_STRIDE), .CMP_OFF(CMP_OFF)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .csr_we(csr_we), .cmp_we(cmp_we)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tcmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt_i(cnt_in),
      .csr_we(csr_we[g]), .csr_wd(w_csr),
      .cmp_we(cmp_we[g]), .cmp_wd(wr_data[CNT_W-1:0]),
      .csr_o(csr_arr[g]), .act_o(act_arr[g]), .pin_o(ch_pin[g])
    );
    assign flag_vec[g] = csr_arr[g].flag;
    assign irq_vec[g]  = csr_arr[g].flag & csr_arr[g].ie;
    assign dma_req[g]  = csr_arr[g].flag & csr_arr[g].dma;
  end

  assign irq = |irq_vec;

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == ADDR_W'(SUM_ADDR)) rd_nxt[NUM_CH-1:0] = flag_vec;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(CH_BASE + i * CH_STRIDE))
        rd_nxt = DATA_W'(csr_pack(csr_arr[i]));
      if (rd_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + CMP_OFF))
        rd_nxt = DATA_W'(act_arr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_vec != '0));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !rd_en) |-> $stable(rd_data));
endmodule

// File: tb/tcmp_bank_tb.sv
module tcmp_bank_tb;
  localparam int NC = 4;
  localparam int CW = 8;

  logic        clk = 0;
  logic        rst = 1;
  logic [CW-1:0] cnt_in = 8'hFF;
  logic        wr_en = 0, rd_en = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [NC-1:0] ch_pin, dma_req;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit running = 0;

  always #10 clk = ~clk;

  tcmp_bank #(.NUM_CH(NC), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ch_pin(ch_pin), .dma_req(dma_req), .irq(irq)
  );

  // reference model built from the requirements
  bit       m_flag[NC], m_ie[NC], m_dma[NC], m_av[NC], m_pv[NC], m_pin[NC];
  logic [3:0]    m_mode[NC];
  logic [CW-1:0] m_act[NC], m_pend[NC];
  logic [31:0]   m_rd;

  function automatic logic [11:0] csr_a(int c); return 12'(12'h608 + 8*c); endfunction
  function automatic logic [11:0] cmp_a(int c); return 12'(12'h60C + 8*c); endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    logic [31:0] r = '0;
    if (a == 12'h604) for (int c = 0; c < NC; c++) r[c] = m_flag[c];
    for (int c = 0; c < NC; c++) begin
      if (a == csr_a(c)) r = {24'b0, m_flag[c], m_ie[c], m_mode[c], 1'b0, m_dma[c]};
      if (a == cmp_a(c)) r = {24'b0, m_act[c]};
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NC; c++) begin
        m_flag[c] = 0; m_ie[c] = 0; m_dma[c] = 0; m_av[c] = 0; m_pv[c] = 0;
        m_pin[c] = 0; m_mode[c] = 0; m_act[c] = 0; m_pend[c] = 0;
      end
      m_rd = 0;
    end else begin
      if (rd_en) m_rd = exp_read(rd_addr);
      for (int c = 0; c < NC; c++) begin
        bit cw, pw, hit, nav;
        cw  = wr_en && wr_addr == csr_a(c);
        pw  = wr_en && wr_addr == cmp_a(c);
        hit = m_mode[c] != 0 && m_av[c] && cnt_in == m_act[c];
        if (cw && wr_data[5:2] != m_mode[c]) m_pin[c] = 0;
        else if (hit && m_mode[c] == 4'b0101) m_pin[c] = !m_pin[c];
        else if (hit && m_mode[c] == 4'b1111) m_pin[c] = 1;
        else if (m_mode[c] == 4'b1111) m_pin[c] = 0;
        if (hit) m_flag[c] = 1; else if (cw && wr_data[7]) m_flag[c] = 0;
        if (cw && wr_data[5:2] == 0) begin
          m_av[c] = 0; m_pv[c] = 0;
        end else begin
          nav = hit ? m_pv[c] : m_av[c];
          if (hit) begin
            if (m_pv[c]) m_act[c] = m_pend[c];
            m_av[c] = m_pv[c]; m_pv[c] = 0;
          end
          if (pw) begin
            if (nav) begin m_pend[c] = wr_data[CW-1:0]; m_pv[c] = 1; end
            else     begin m_act[c]  = wr_data[CW-1:0]; m_av[c] = 1; end
          end
        end
        if (cw) begin m_ie[c] = wr_data[6]; m_mode[c] = wr_data[5:2]; m_dma[c] = wr_data[0]; end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) if (running && !rst) begin
    logic [NC-1:0] ep, ed; logic ei;
    ei = 0;
    for (int c = 0; c < NC; c++) begin
      ep[c] = m_pin[c]; ed[c] = m_flag[c] & m_dma[c]; ei |= m_flag[c] & m_ie[c];
    end
    chk(ch_pin == ep, "R6/R7 pins", 32'(ch_pin), 32'(ep));
    chk(dma_req == ed && irq == ei, "R11 irq/dma", {dma_req, 3'b0, irq}, {ed, 3'b0, ei});
    chk(rd_data == m_rd, "R2 rd_data", rd_data, m_rd);
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic tick(logic [CW-1:0] v);
    @(negedge clk); cnt_in = v;
    @(negedge clk); cnt_in = 8'hFF;
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    running = 1;
    // R1 reset state
    chk(ch_pin == 0 && irq == 0 && dma_req == 0, "R1 outputs", {ch_pin, dma_req, 23'b0, irq}, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    rd(12'h604, d); chk(d == 0, "R1 summary", d, 0);
    rd(csr_a(3), d); chk(d == 0, "R1 csr", d, 0);
    // R8 two-stage fill, R3 layout
    wr(csr_a(0), 32'h80);
    wr(cmp_a(0), 32'h10);
    wr(cmp_a(0), 32'h20);
    rd(cmp_a(0), d); chk(d == 32'h10, "R8 armed first", d, 32'h10);
    wr(csr_a(0), 32'hFFFF_FF56);
    rd(csr_a(0), d); chk(d == 32'h54, "R3 layout", d, 32'h54);
    // R4/R6 first match
    @(negedge clk); cnt_in = 8'h10;
    @(negedge clk); cnt_in = 8'hFF;
    chk(ch_pin[0] == 1, "R6 toggle up", 32'(ch_pin), 1);
    chk(irq == 1, "R11 irq", 32'(irq), 1);
    rd(12'h604, d); chk(d == 1, "R4 flag", d, 1);
    rd(cmp_a(0), d); chk(d == 32'h20, "R8 promote", d, 32'h20);
    // R5 clear
    wr(csr_a(0), 32'hD4);
    chk(irq == 0, "R5 w1c", 32'(irq), 0);
    @(negedge clk); cnt_in = 8'h20;
    @(negedge clk);
    chk(ch_pin[0] == 0, "R6 toggle down", 32'(ch_pin), 0);
    wr(csr_a(0), 32'hD4);
    repeat (3) @(negedge clk);
    rd(12'h604, d); chk(d == 0, "R8 disarm after last", d, 0);
    cnt_in = 8'hFF;
    // R9 overwrite pending, R7 pulse
    wr(cmp_a(1), 32'h30); wr(cmp_a(1), 32'h31); wr(cmp_a(1), 32'h32);
    wr(csr_a(1), 32'h3D);
    @(negedge clk); cnt_in = 8'h30;
    @(negedge clk); cnt_in = 8'h00;
    chk(ch_pin[1] == 1 && dma_req[1] == 1, "R7 pulse/R11 dma", {ch_pin, dma_req}, 8'h22);
    @(negedge clk);
    chk(ch_pin[1] == 0, "R7 one cycle", 32'(ch_pin), 0);
    cnt_in = 8'hFF;
    rd(cmp_a(1), d); chk(d == 32'h32, "R9 overwrite", d, 32'h32);
    // R5 set wins over clear
    @(negedge clk); cnt_in = 8'h32; wr_en = 1; wr_addr = csr_a(1); wr_data = 32'hBD;
    @(negedge clk); wr_en = 0; cnt_in = 8'hFF;
    rd(12'h604, d); chk(d == 2, "R5 set wins", d, 2);
    // R10 disarm by mode 0
    wr(cmp_a(2), 32'h40); wr(csr_a(2), 32'h14); wr(csr_a(2), 32'h00);
    tick(8'h40);
    chk(ch_pin[2] == 0, "R10 pin", 32'(ch_pin), 0);
    rd(12'h604, d); chk(d == 2, "R10 no flag", d, 2);
    // R12 mode change drops pin
    wr(cmp_a(2), 32'h41); wr(csr_a(2), 32'h14);
    tick(8'h41);
    chk(ch_pin[2] == 1, "R6 ch2 toggle", 32'(ch_pin), 32'h4);
    wr(csr_a(2), 32'h3C);
    chk(ch_pin[2] == 0, "R12 mode change", 32'(ch_pin), 0);
    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      int c, op, mi;
      logic [3:0] md [4];
      md[0] = 4'b0000; md[1] = 4'b0101; md[2] = 4'b1111; md[3] = 4'b0011;
      @(negedge clk);
      cnt_in = CW'($urandom % 16);
      c  = int'($urandom % NC);
      op = int'($urandom % 10);
      wr_en = 0;
      if (op < 2) begin
        mi = int'($urandom % 8);
        wr_en = 1; wr_addr = csr_a(c);
        wr_data = {24'($urandom), ($urandom % 3) == 0, 1'($urandom),
                   md[mi < 4 ? mi : (mi < 6 ? 1 : 2)], 2'($urandom)};
      end else if (op < 5) begin
        wr_en = 1; wr_addr = cmp_a(c); wr_data = 32'($urandom % 16);
      end
      rd_en = 1;
      rd_addr = (op == 9) ? 12'h604 : (($urandom % 2) ? csr_a(c) : cmp_a(c));
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    repeat (2) @(negedge clk);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: got=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule